// File: doc/BRIEF.md
# Parallel Multi-Bit CRC Update

This block folds a chunk of N message bits into a 5-bit CRC register on every clock where the chunk is marked valid, using the generator x^5 + x^2 + 1. The next register value is a pure XOR function of two things only: the N bits of the current chunk and the register value left by the previous update. That function is a single level of XOR combining per-bit contribution masks. The masks are worked out while the design is elaborated. Each mask records how one lone input bit, or one lone register bit, travels through N steps of the bit-serial engine. Because the function is linear, the XOR of those single-bit responses gives the full update.

The register is cleared with a synchronous clear and holds its value on any cycle where no chunk is offered. A message is processed by clearing the register once and then presenting its chunks in order. The most significant bit of each chunk is the earliest bit in the message. The register value after the last chunk is the remainder of the message multiplied by x^5 and divided by the generator. The block does not handle partial chunks, bit reflection or a final inversion.

Top module: `crc_par_update`

## Requirements
- R1: When `clr` is high at a rising edge, `crc_out` becomes 0 after that edge, whatever `data_valid` and `data_in` are.
- R2: When `clr` and `data_valid` are both low at a rising edge, `crc_out` keeps its value.
- R3: When `data_valid` is high and `clr` is low, `crc_out` takes the value that the serial engine reaches after N steps, starting from the current `crc_out`. Bits are fed from `data_in[N-1]` down to `data_in[0]`. One serial step with input bit b is: f = crc[4] XOR b; crc = (crc shifted left by one, bit 0 filled with 0) XOR (f ? 5'b00101 : 0).
- R4: From a cleared register, the result for a chunk a XOR b equals the XOR of the results for chunk a alone and chunk b alone.
- R5: With N = 8, a single valid chunk 8'b11011010 applied to a cleared register gives `crc_out` = 5'h14.
- R6: An all-zero chunk applied to a zero register leaves `crc_out` at 0.
- R7: Two valid chunks in a row give the same result as 2N serial steps over the first chunk followed by the second, with idle cycles between them having no effect.
- R8: For every single set bit position j of `data_in`, one valid chunk on a cleared register gives the serial engine's response to that lone bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| clr | input | 1 | Synchronous clear of the CRC register, highest priority |
| data_valid | input | 1 | Marks `data_in` as a chunk to fold in this cycle |
| data_in | input | N | Message chunk, MSB is the earliest serial bit |
| crc_out | output | 5 | Current CRC register value |

## Verification
Some contribution masks are hard to reach from the ports. These are the masks of the register bits, and above all the high bit, whose feedback passes through all N steps. They are exercised only when the register already holds a chosen non-zero value at the moment a chunk arrives. Random chunk streams drive the register through many states, and each update is compared with a bench serial model. Every lone data bit is also applied to a cleared register, so each data mask is tested on its own. Superposition triples and the known vector pin down the linear structure directly.

// File: rtl/crc_par_pkg.sv
package crc_par_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_FOLD  = 2'd1,
        CMD_CLEAR = 2'd2
    } crc_cmd_e;

    function automatic crc_cmd_e decode_cmd(input logic clr_i, input logic valid_i);
        crc_cmd_e c;
        if (clr_i)        c = CMD_CLEAR;
        else if (valid_i) c = CMD_FOLD;
        else              c = CMD_HOLD;
        return c;
    endfunction

endpackage

// File: rtl/crc_contrib_matrix.sv
module crc_contrib_matrix #(
    parameter int unsigned         N     = 8,
    parameter int unsigned         CRC_W = 5,
    parameter logic [CRC_W-1:0]    POLY  = 5'h05
) (
    output logic [N*CRC_W-1:0]     data_resp,
    output logic [CRC_W*CRC_W-1:0] state_resp
);

    function automatic logic [CRC_W-1:0] one_step(input logic [CRC_W-1:0] st, input logic b);
        logic fb;
        logic [CRC_W-1:0] nx;
        fb = st[CRC_W-1] ^ b;
        nx = {st[CRC_W-2:0], 1'b0};
        if (fb) nx = nx ^ POLY;
        return nx;
    endfunction

    // response of N serial steps to a lone chunk bit j (state starts at zero)
    function automatic logic [CRC_W-1:0] data_row(input int j);
        logic [CRC_W-1:0] st;
        st = '0;
        for (int k = 0; k < int'(N); k++) begin
            st = one_step(st, (k == int'(N) - 1 - j));
        end
        return st;
    endfunction

    // response of N serial steps to a lone register bit i (data all zero)
    function automatic logic [CRC_W-1:0] state_row(input int i);
        logic [CRC_W-1:0] st;
        st = '0;
        st[i] = 1'b1;
        for (int k = 0; k < int'(N); k++) begin
            st = one_step(st, 1'b0);
        end
        return st;
    endfunction

    for (genvar j = 0; j < int'(N); j++) begin : g_data_row
        localparam logic [CRC_W-1:0] ROW = data_row(j);
        assign data_resp[j*CRC_W +: CRC_W] = ROW;
    end

    for (genvar i = 0; i < int'(CRC_W); i++) begin : g_state_row
        localparam logic [CRC_W-1:0] ROW = state_row(i);
        assign state_resp[i*CRC_W +: CRC_W] = ROW;
    end

endmodule

// File: rtl/crc_xor_net.sv
module crc_xor_net #(
    parameter int unsigned N     = 8,
    parameter int unsigned CRC_W = 5
) (
    input  logic [N-1:0]           chunk,
    input  logic [CRC_W-1:0]       state,
    input  logic [N*CRC_W-1:0]     data_resp,
    input  logic [CRC_W*CRC_W-1:0] state_resp,
    output logic [CRC_W-1:0]       next_state
);

    always_comb begin
        next_state = '0;
        for (int j = 0; j < int'(N); j++) begin
            if (chunk[j]) next_state = next_state ^ data_resp[j*CRC_W +: CRC_W];
        end
        for (int i = 0; i < int'(CRC_W); i++) begin
            if (state[i]) next_state = next_state ^ state_resp[i*CRC_W +: CRC_W];
        end
    end

endmodule

// File: rtl/crc_par_update.sv
module crc_par_update
    import crc_par_pkg::*;
#(
    parameter int unsigned      N     = 8,
    parameter int unsigned      CRC_W = 5,
    parameter logic [CRC_W-1:0] POLY  = 5'h05
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             data_valid,
    input  logic [N-1:0]     data_in,
    output logic [CRC_W-1:0] crc_out
);

    localparam int unsigned DATA_RESP_W  = N * CRC_W;
    localparam int unsigned STATE_RESP_W = CRC_W * CRC_W;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_state_t;

    crc_state_t s_d, s_q;
    crc_cmd_e   cmd;

    logic [DATA_RESP_W-1:0]  data_resp;
    logic [STATE_RESP_W-1:0] state_resp;
    logic [CRC_W-1:0]        fold_val;

    crc_contrib_matrix #(.N(N), .CRC_W(CRC_W), .POLY(POLY)) u_matrix (
        .data_resp  (data_resp),
        .state_resp (state_resp)
    );

    crc_xor_net #(.N(N), .CRC_W(CRC_W)) u_xor (
        .chunk      (data_in),
        .state      (s_q.crc),
        .data_resp  (data_resp),
        .state_resp (state_resp),
        .next_state (fold_val)
    );

    always_comb begin
        cmd = decode_cmd(clr, data_valid);
        s_d = s_q;
        unique case (cmd)
            CMD_CLEAR: s_d.crc = '0;
            CMD_FOLD:  s_d.crc = fold_val;
            default:   s_d     = s_q;
        endcase
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign crc_out = s_q.crc;

endmodule

// File: rtl/crc_par_update_chk.sv
module crc_par_update_chk #(
    parameter int unsigned      N     = 8,
    parameter int unsigned      CRC_W = 5,
    parameter logic [CRC_W-1:0] POLY  = 5'h05
) (
    input logic             clk,
    input logic             clr,
    input logic             data_valid,
    input logic [N-1:0]     data_in,
    input logic [CRC_W-1:0] crc_out
);

    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (clr) armed_q <= 1'b1;
    end

    logic [CRC_W-1:0] serial_ref;
    always_comb begin
        serial_ref = crc_out;
        for (int k = int'(N) - 1; k >= 0; k--) begin
            if (serial_ref[CRC_W-1] ^ data_in[k])
                serial_ref = {serial_ref[CRC_W-2:0], 1'b0} ^ POLY;
            else
                serial_ref = {serial_ref[CRC_W-2:0], 1'b0};
        end
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed_q)
        clr |=> (crc_out == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr && !data_valid) |=> $stable(crc_out)); // R2

    AST_FOLD_SERIAL: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr && data_valid) |=> (crc_out == $past(serial_ref))); // R3

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr && data_valid && data_in == '0 && crc_out == '0) |=> (crc_out == '0)); // R6

endmodule

bind crc_par_update crc_par_update_chk #(.N(N), .CRC_W(CRC_W), .POLY(POLY)) u_chk (
    .clk        (clk),
    .clr        (clr),
    .data_valid (data_valid),
    .data_in    (data_in),
    .crc_out    (crc_out)
);

// File: tb/sim_crc_par_update.sv
module sim_crc_par_update;

    localparam int  N      = 8;
    localparam int  W      = 5;
    localparam time CLK_PD = 10ns;

    logic         clk = 1'b0;
    logic         clr = 1'b0;
    logic         data_valid = 1'b0;
    logic [N-1:0] data_in = '0;
    logic [W-1:0] crc_out;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #(CLK_PD/2) clk = ~clk;

    crc_par_update #(.N(N), .CRC_W(W), .POLY(5'h05)) u0 (
        .clk(clk), .clr(clr), .data_valid(data_valid),
        .data_in(data_in), .crc_out(crc_out)
    );

    function automatic logic [W-1:0] ser(input logic [W-1:0] s, input logic b);
        logic f;
        f = s[W-1] ^ b;
        s = s << 1;
        if (f) s = s ^ 5'b00101;
        return s;
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [N-1:0] d);
        for (int k = N - 1; k >= 0; k--) s = ser(s, d[k]);
        return s;
    endfunction

    task automatic cyc(input logic c, input logic v, input logic [N-1:0] d);
        clr = c; data_valid = v; data_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] exp);
        compared++;
        if (crc_out !== exp) begin
            mismatched++;
            $display("FAIL %s: crc_out=%h expected=%h", req, crc_out, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] exp, ra, rb, rab, held;
        logic [N-1:0] a, b, d0, d1;
        void'($urandom(32'd20240611));
        @(negedge clk);

        // R1: clear from unknown state
        cyc(1, 0, '0);
        check("R1 reset", '0);

        // R5: known vector
        cyc(0, 1, 8'b11011010);
        check("R5 vector", 5'h14);

        // R1: clear wins over valid
        cyc(1, 1, 8'hFF);
        check("R1 clear priority", '0);

        // R6: zero chunk on zero register
        cyc(0, 1, '0);
        check("R6 zero chunk", '0);

        // R8: lone bits
        for (int j = 0; j < N; j++) begin
            cyc(1, 0, '0);
            cyc(0, 1, N'(1) << j);
            check($sformatf("R8 bit %0d", j), model('0, N'(1) << j));
        end

        // R4: superposition
        for (int t = 0; t < 20; t++) begin
            a = N'($urandom); b = N'($urandom);
            cyc(1, 0, '0); cyc(0, 1, a); ra = crc_out;
            cyc(1, 0, '0); cyc(0, 1, b); rb = crc_out;
            cyc(1, 0, '0); cyc(0, 1, a ^ b); rab = crc_out;
            compared++;
            if (rab !== (ra ^ rb)) begin
                mismatched++;
                $display("FAIL R4: crc_out=%h expected=%h", rab, ra ^ rb);
            end
        end

        // R7: two chunks with idle cycles between, vs 2N serial steps
        for (int t = 0; t < 20; t++) begin
            d0 = N'($urandom); d1 = N'($urandom);
            cyc(1, 0, '0);
            cyc(0, 1, d0);
            cyc(0, 0, N'($urandom));
            cyc(0, 0, N'($urandom));
            cyc(0, 1, d1);
            exp = '0;
            for (int k = N - 1; k >= 0; k--) exp = ser(exp, d0[k]);
            for (int k = N - 1; k >= 0; k--) exp = ser(exp, d1[k]);
            check("R7 chained", exp);
        end

        // R3 / R2: random stream with idle and clear cycles
        cyc(1, 0, '0);
        exp = '0;
        for (int t = 0; t < 400; t++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) begin
                cyc(1, 1, N'($urandom));
                exp = '0;
                check("R1 random clear", exp);
            end else if (r < 5) begin
                held = exp;
                cyc(0, 0, N'($urandom));
                check("R2 idle hold", held);
            end else begin
                d0 = N'($urandom);
                exp = model(exp, d0);
                cyc(0, 1, d0);
                check("R3 fold", exp);
            end
        end

        // R3: state masks from a chosen register value, all-ones and zero chunks
        cyc(1, 0, '0);
        cyc(0, 1, 8'hFF);
        exp = model('0, 8'hFF);
        check("R3 ones", exp);
        cyc(0, 1, 8'h00);
        exp = model(exp, 8'h00);
        check("R3 state only", exp);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule